// File: doc/BRIEF.md
# Binary-Activation Convolution Engine

The engine computes one output channel of a K×K convolution whose input activations are single bits. A window of `CH` channels × `KS` × `KS` bits arrives on one cycle. For each tap the engine passes either that tap's signed weight or zero, depending on the activation bit. It adds up the selected values in a registered adder tree and then adds a signed bias. With the defaults (8 channels, 3×3 kernel) the engine replaces 72 multiplications with 72 two-way selects.

A small mode controller separates configuration from computation. In the load mode, weights enter through an address/data/write-enable port and windows are refused. In the run mode, the engine takes one window per clock and the weights are frozen. When the run request drops, a drain mode lasts exactly as long as the pipeline, so every accepted window still produces its result. The controller then returns to the load mode.

The controller has three states. `ST_LOAD` is the configuration state and the state after reset. `ST_RUN` is the compute state. `ST_DRAIN` empties the pipeline. It has four transitions:
- **arm**: `ST_LOAD` → `ST_RUN` when `run_en` is 1.
- **stop**: `ST_RUN` → `ST_DRAIN` when `run_en` is 0.
- **emptied**: `ST_DRAIN` → `ST_LOAD` after `LAT` cycles in drain.
- **hold**: every other case keeps the current state.

Top module: `binconv_core`

## Requirements
- R1: Tap t = (c·KS + row)·KS + col is bit t of `win_bits`, and its weight is the one written at address t. A tap contributes its weight when its bit is 1 and contributes zero when its bit is 0.
- R2: `out_sum` is the signed sum of all contributing weights plus the sign-extended `bias`. It is exact and never wraps at width `WW + LV + 1`, where LV = max(1, ceil(log2(CH·KS·KS))).
- R3: A window taken on clock edge n produces `out_valid` = 1 with its result after edge n+LV+1. One window can be taken every cycle, and results leave in the order the windows were taken.
- R4: After reset the state is `ST_LOAD`, `out_valid` = 0, `out_sum` = 0, `wr_ready` = 1, and every weight is zero.
- R5: In `ST_LOAD`, `wr_ready` = 1 and a write with `wr_en` = 1 stores `wr_data` at `wr_addr`. Any window presented in this state is ignored and never produces `out_valid`.
- R6: In `ST_LOAD`, `run_en` = 1 moves the engine to `ST_RUN` at the next edge. `wr_ready` then reads 0, and windows are taken from that cycle on.
- R7: Writes presented in `ST_RUN` or `ST_DRAIN` leave the weights unchanged.
- R8: In `ST_RUN`, `run_en` = 0 moves the engine to `ST_DRAIN`. The drain lasts LAT = LV+2 cycles and then returns to `ST_LOAD`. Windows presented during the drain are ignored, but every window taken earlier is still delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Request for the compute state |
| wr_en | input | 1 | Weight write strobe |
| wr_addr | input | clog2(CH·KS·KS) | Tap index of the weight being written |
| wr_data | input | WW | Signed weight value |
| wr_ready | output | 1 | High while weight writes are accepted |
| win_valid | input | 1 | A window is presented |
| win_bits | input | CH·KS·KS | Binary activations, one bit per tap |
| bias | input | WW | Signed bias, taken with the window |
| out_valid | output | 1 | `out_sum` holds a new result |
| out_sum | output | WW+LV+1 | Signed convolution result |

## Verification
A corrupted weight register, or a tap select that picks the wrong source, shows as a wrong `out_sum` within LV+2 cycles of the first window that sets that tap's bit. An exhaustive sweep of all bit patterns therefore exposes it at once. A misaligned bias stage or tree stage shows as results that carry a neighbouring window's bias or arrive one cycle off. A mode controller that leaves the wrong state too early or too late shows on `wr_ready` at the drain boundary, as `out_valid` pulses for refused windows, or as a write during run that leaks into later results.

// File: rtl/binconv_pkg.sv
package binconv_pkg;

    typedef enum logic [1:0] {
        ST_LOAD  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } mode_e;

    // number of registered adder levels for n leaves (at least one)
    function automatic int tree_levels(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/binconv_wmem.sv
module binconv_wmem #(
    parameter int TAPS = 72,
    parameter int WW   = 16,
    parameter int AW   = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_ok,
    input  logic [AW-1:0]             wr_addr,
    input  logic [WW-1:0]             wr_data,
    output logic [TAPS-1:0][WW-1:0]   wq
);

    for (genvar t = 0; t < TAPS; t++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                wq[t] <= '0;
            end else if (wr_ok && (wr_addr == AW'(t))) begin
                wq[t] <= wr_data;
            end
        end
    end

    // R7
    wq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ok |=> $stable(wq));

endmodule

// File: rtl/binconv_select.sv
module binconv_select #(
    parameter int TAPS = 72,
    parameter int WW   = 16,
    parameter int SW   = 23
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      take,
    input  logic [TAPS-1:0]           bits,
    input  logic [TAPS-1:0][WW-1:0]   wq,
    output logic [TAPS-1:0][SW-1:0]   leaf,
    output logic                      leaf_vld
);

    for (genvar t = 0; t < TAPS; t++) begin : g_tap
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                leaf[t] <= '0;
            end else if (take) begin
                leaf[t] <= bits[t] ? {{(SW-WW){wq[t][WW-1]}}, wq[t]} : '0;
            end
        end

        // R1
        leaf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (take && !bits[t]) |=> (leaf[t] == '0));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) leaf_vld <= 1'b0;
        else        leaf_vld <= take;
    end

endmodule

// File: rtl/binconv_tree.sv
module binconv_tree #(
    parameter int TAPS = 72,
    parameter int WW   = 16,
    parameter int LV   = 7,
    parameter int SW   = 23
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [TAPS-1:0][SW-1:0]   leaf,
    input  logic                      leaf_vld,
    output logic [SW-1:0]             root,
    output logic                      root_vld
);

    localparam int NP = 1 << LV;
    localparam longint HI = longint'(TAPS) * ((64'sd1 <<< (WW-1)) - 1);
    localparam longint LO = -(longint'(TAPS) * (64'sd1 <<< (WW-1)));

    logic [SW-1:0] pad [NP];
    logic [SW-1:0] acc [1:NP-1];
    logic [LV-1:0] vq;

    for (genvar n = 0; n < NP; n++) begin : g_pad
        if (n < TAPS) begin : g_real
            assign pad[n] = leaf[n];
        end else begin : g_fill
            assign pad[n] = '0;
        end
    end

    for (genvar n = 1; n < NP; n++) begin : g_node
        if (2 * n >= NP) begin : g_low
            always_ff @(posedge clk) begin
                if (!rst_n) acc[n] <= '0;
                else        acc[n] <= pad[2*n-NP] + pad[2*n+1-NP];
            end
        end else begin : g_high
            always_ff @(posedge clk) begin
                if (!rst_n) acc[n] <= '0;
                else        acc[n] <= acc[2*n] + acc[2*n+1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) vq <= '0;
        else        vq <= LV'({vq, leaf_vld});
    end

    assign root     = acc[1];
    assign root_vld = vq[LV-1];

    // R2
    root_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        root_vld |-> ((longint'($signed(root)) <= HI) && (longint'($signed(root)) >= LO)));

endmodule

// File: rtl/binconv_core.sv
module binconv_core
    import binconv_pkg::*;
#(
    parameter int CH = 8,
    parameter int KS = 3,
    parameter int WW = 16
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        run_en,
    input  logic                                        wr_en,
    input  logic [$clog2(CH*KS*KS)-1:0]                 wr_addr,
    input  logic [WW-1:0]                               wr_data,
    output logic                                        wr_ready,
    input  logic                                        win_valid,
    input  logic [CH*KS*KS-1:0]                         win_bits,
    input  logic [WW-1:0]                               bias,
    output logic                                        out_valid,
    output logic [WW+tree_levels(CH*KS*KS):0]           out_sum
);

    localparam int TAPS = CH * KS * KS;
    localparam int AW   = $clog2(TAPS);
    localparam int LV   = tree_levels(TAPS);
    localparam int SW   = WW + LV;
    localparam int OW   = SW + 1;
    localparam int LAT  = LV + 2;
    localparam int CW   = $clog2(LAT + 1);

    mode_e   state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic    wr_ok, take;

    logic [TAPS-1:0][WW-1:0] wq;
    logic [TAPS-1:0][SW-1:0] leaf;
    logic                    leaf_vld;
    logic [SW-1:0]           root;
    logic                    root_vld;
    logic [WW-1:0]           bq [0:LV];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOAD;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD:  if (run_en)                   state_d = ST_RUN;
            ST_RUN:   if (!run_en)                  state_d = ST_DRAIN;
            ST_DRAIN: if (cnt_q == CW'(LAT - 1))    state_d = ST_LOAD;
            default:                                state_d = ST_LOAD;
        endcase
    end

    // state-dependent outputs and enables
    always_comb begin
        wr_ready = 1'b0;
        take     = 1'b0;
        unique case (state_q)
            ST_LOAD:  wr_ready = 1'b1;
            ST_RUN:   take     = win_valid;
            ST_DRAIN: ;
            default:  ;
        endcase
        wr_ok = wr_en && wr_ready;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || state_q != ST_DRAIN) cnt_q <= '0;
        else                               cnt_q <= cnt_q + 1'b1;
    end

    binconv_wmem #(.TAPS(TAPS), .WW(WW), .AW(AW)) i_wmem (
        .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok),
        .wr_addr(wr_addr), .wr_data(wr_data), .wq(wq)
    );

    binconv_select #(.TAPS(TAPS), .WW(WW), .SW(SW)) i_select (
        .clk(clk), .rst_n(rst_n), .take(take), .bits(win_bits),
        .wq(wq), .leaf(leaf), .leaf_vld(leaf_vld)
    );

    binconv_tree #(.TAPS(TAPS), .WW(WW), .LV(LV), .SW(SW)) i_tree (
        .clk(clk), .rst_n(rst_n), .leaf(leaf), .leaf_vld(leaf_vld),
        .root(root), .root_vld(root_vld)
    );

    // bias travels beside the window through the tree
    always_ff @(posedge clk) begin
        if (!rst_n)    bq[0] <= '0;
        else if (take) bq[0] <= bias;
    end

    for (genvar k = 1; k <= LV; k++) begin : g_bias
        always_ff @(posedge clk) begin
            if (!rst_n) bq[k] <= '0;
            else        bq[k] <= bq[k-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sum   <= '0;
        end else begin
            out_valid <= root_vld;
            if (root_vld) begin
                out_sum <= {root[SW-1], root} + {{(OW-WW){bq[LV][WW-1]}}, bq[LV]};
            end
        end
    end

    // R5
    idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD) |-> !out_valid);

    // R6
    load_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD && run_en) |=> (state_q == ST_RUN));

    // R8
    drain_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN) |-> (cnt_q < CW'(LAT)));

endmodule

// File: tb/test_binconv_core.sv
module test_binconv_core;

    localparam int CH   = 2;
    localparam int KS   = 2;
    localparam int WW   = 16;
    localparam int TAPS = CH * KS * KS;
    localparam int AW   = $clog2(TAPS);
    localparam int LV   = 3;
    localparam int OW   = WW + LV + 1;
    localparam int LAT  = LV + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_en = 1'b0;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [WW-1:0] wr_data = '0;
    logic wr_ready;
    logic win_valid = 1'b0;
    logic [TAPS-1:0] win_bits = '0;
    logic [WW-1:0] bias = '0;
    logic out_valid;
    logic [OW-1:0] out_sum;

    int checks = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 1'b0;
    longint wm [TAPS];
    longint exp_sum [$];
    int     exp_cyc [$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    binconv_core #(.CH(CH), .KS(KS), .WW(WW)) i_binconv_core (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
        .win_valid(win_valid), .win_bits(win_bits), .bias(bias),
        .out_valid(out_valid), .out_sum(out_sum)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // output monitor: R1 R2 values, R3 timing, R5 R8 no stray results
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_sum.size() == 0) begin
                chk(1'b0, "R5 R8 unexpected out_valid", 1, 0);
            end else begin
                longint es;
                int ec;
                es = exp_sum.pop_front();
                ec = exp_cyc.pop_front();
                chk(longint'($signed(out_sum)) == es, "R1 R2 out_sum",
                    longint'($signed(out_sum)), es);
                chk(cyc == ec, "R3 result cycle", cyc, ec);
            end
        end
    end

    function automatic longint model(input logic [TAPS-1:0] b, input logic [WW-1:0] bs);
        longint s = longint'($signed(bs));
        for (int t = 0; t < TAPS; t++) if (b[t]) s += wm[t];
        return s;
    endfunction

    task automatic wr(input int a, input longint d, input bit accepted);
        wr_en = 1'b1;
        wr_addr = AW'(a);
        wr_data = WW'(d);
        @(negedge clk);
        wr_en = 1'b0;
        if (accepted) wm[a] = longint'($signed(WW'(d)));
    endtask

    task automatic send(input logic [TAPS-1:0] b, input longint bs, input bit taken);
        win_valid = 1'b1;
        win_bits = b;
        bias = WW'(bs);
        if (taken) begin
            exp_sum.push_back(model(b, WW'(bs)));
            exp_cyc.push_back(cyc + 1 + LV + 1);
        end
        @(negedge clk);
        win_valid = 1'b0;
    endtask

    task automatic go_run();
        run_en = 1'b1;
        @(negedge clk);
        chk(wr_ready == 1'b0, "R6 wr_ready low in run", wr_ready, 0);
    endtask

    task automatic stop_run();
        run_en = 1'b0;
        @(negedge clk);
        repeat (LAT - 1) @(negedge clk);
        chk(wr_ready == 1'b0, "R8 still draining", wr_ready, 0);
        @(negedge clk);
        chk(wr_ready == 1'b1, "R8 back to load", wr_ready, 1);
    endtask

    task automatic sweep(input longint bbase);
        for (int i = 0; i < (1 << TAPS); i++) send(TAPS'(i), bbase + i * 37, 1'b1);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            checks++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 200000);
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        for (int t = 0; t < TAPS; t++) wm[t] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R4 reset state
        chk(out_valid == 1'b0, "R4 out_valid", out_valid, 0);
        chk(out_sum == '0, "R4 out_sum", longint'(out_sum), 0);
        chk(wr_ready == 1'b1, "R4 wr_ready", wr_ready, 1);

        // R5 windows in load are ignored
        send('1, 7, 1'b0);
        send('1, 9, 1'b0);
        repeat (LAT + 2) @(negedge clk);

        // R4 weights cleared: all-ones window gives the bias only
        go_run();
        send('1, 5, 1'b1);
        send('1, -5, 1'b1);
        stop_run();

        // R1 R2 R3 exhaustive sweep with mixed weights
        for (int t = 0; t < TAPS; t++) wr(t, (t * 9001 + 123) % 65536 - 32768, 1'b1);
        go_run();
        sweep(-4000);
        stop_run();

        // R2 largest positive sums
        for (int t = 0; t < TAPS; t++) wr(t, 32767, 1'b1);
        go_run();
        send('1, 32767, 1'b1);
        sweep(0);
        stop_run();

        // R2 largest negative sums
        for (int t = 0; t < TAPS; t++) wr(t, -32768, 1'b1);
        go_run();
        send('1, -32768, 1'b1);
        stop_run();

        // R1 single-tap windows with distinct weights, R3 gapped arrivals
        for (int t = 0; t < TAPS; t++) wr(t, (t + 1) * 111 * ((t % 2) ? -1 : 1), 1'b1);
        go_run();
        for (int t = 0; t < TAPS; t++) begin
            send(TAPS'(1) << t, 0, 1'b1);
            repeat (t % 3) @(negedge clk);
        end
        // R7 write during run is ignored
        wr(0, 1234, 1'b0);
        send(TAPS'(1), 0, 1'b1);
        // R8 window presented on the stop cycle is still taken
        run_en = 1'b0;
        send(TAPS'(3), 10, 1'b1);
        // R7 write during drain is ignored, R8 windows in drain ignored
        wr(1, 4321, 1'b0);
        send('1, 1, 1'b0);
        repeat (LAT) @(negedge clk);
        chk(wr_ready == 1'b1, "R8 load after drain", wr_ready, 1);
        go_run();
        send(TAPS'(3), 0, 1'b1);
        stop_run();

        // R5 write accepted in load, R6 first run cycle takes a window
        wr(2, -777, 1'b1);
        run_en = 1'b1;
        @(negedge clk);
        send(TAPS'(4), 3, 1'b1);
        stop_run();

        repeat (LAT + 2) @(negedge clk);
        chk(exp_sum.size() == 0, "R3 all results delivered", exp_sum.size(), 0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule